// File: doc/BRIEF.md
# Segment LCD Frame Buffer Sequencer

This block sits inside a segment LCD controller between software and the segment drivers. Software writes pixel words into a user buffer at any time. A second buffer, the display buffer, holds the pixels that are being shown. At each frame-start strobe the sequencer applies the display mode that software last wrote, and in refresh modes it copies the whole user buffer into the display buffer. The mode never changes in the middle of a frame.

Besides plain refresh there are three other display behaviours. A blink mode turns the pixels off and on at each blink tick. A load-only mode freezes the display buffer so that software can prepare a second image. A swap mode then alternates the shown image between the two buffers at each blink tick, so two full images alternate with no software rewrites. A disable request lets the current frame finish, drives one complete frame with every output grounded, and then turns the block off and raises an interrupt. A soft reset clears everything.

Top module: `segFrameSeq`

## Requirements
- R1: After reset the block is off. `allGround`=1, `pixOut`=0, `active`=0, `disBusy`=0 and `disIrq`=0. The mode is normal, the interrupt enable is 0, and both buffers hold zero. An `enableReq` pulse turns the block on.
- R2: A `bufWr` pulse stores `bufData` into user word `bufAddr`, which maps to pixels `bufAddr*WORD_W` to `bufAddr*WORD_W+WORD_W-1` (LSB first). In normal mode (code 0) the whole user buffer is copied to the display buffer on every `frameStart`. A write made before a frame start appears on `pixOut` in the cycle after that strobe.
- R3: A `cfgWr` pulse records `cfgMode` and `cfgIrqEn`. The recorded mode is applied only at the next `frameStart`; until then the previous mode governs copying and blink ticks.
- R4: Mode code 6 (load-only) suppresses the copy at frame start, so the display buffer and `pixOut` keep their contents while the user buffer changes.
- R5: In mode code 7 (swap), each `blinkTick` flips the shown source between the display buffer and the user buffer. Entering the mode starts on the display buffer, and no copy happens at frame start.
- R6: In mode code 1 (blink), the buffer is copied every frame as in normal mode, and each `blinkTick` alternates `pixOut` between all-off and the display buffer. Entering the mode starts with the pixels shown.
- R7: A `disableReq` while the block is on sets `disBusy`. The frame that is running when the request arrives completes normally. The next frame that starts is an all-ground frame, with `allGround`=1 and `pixOut`=0.
- R8: At the `frameEnd` of the all-ground frame, `disBusy` and `active` drop, the interrupt flag is set, and `disIrq` shows the flag ANDed with the enable bit written by `cfgWr`.
- R9: The interrupt flag stays set until an `irqClr` pulse clears it.
- R10: Disabling keeps both buffers and the mode. After an `enableReq`, the previous display contents reappear with no frame needed.
- R11: A `softReset` pulse returns all state, including both buffers, to the R1 reset values.
- R12: Mode codes 2 to 5 behave as normal mode: the buffer is copied every frame and blink ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | One-cycle strobe at the first cycle of a frame |
| frameEnd | input | 1 | One-cycle strobe at the last cycle of a frame |
| blinkTick | input | 1 | One-cycle strobe at the blink rate |
| cfgWr | input | 1 | Configuration write strobe |
| cfgMode | input | 3 | Display mode code |
| cfgIrqEn | input | 1 | Interrupt enable value |
| enableReq | input | 1 | Turn the block on |
| disableReq | input | 1 | Request a clean shutdown |
| softReset | input | 1 | Synchronous clear of all state |
| irqClr | input | 1 | Write-one-to-clear of the interrupt flag |
| bufWr | input | 1 | User buffer word write strobe |
| bufAddr | input | ADDR_W | User buffer word index |
| bufData | input | WORD_W | User buffer word data |
| pixOut | output | NUM_WORDS*WORD_W | Per-segment pixel data |
| allGround | output | 1 | Drivers must ground every common and segment |
| disIrq | output | 1 | Disable-complete interrupt |
| active | output | 1 | Block is on |
| disBusy | output | 1 | Disable in progress |

## Verification
Most internal faults in this block show up on `pixOut` within one frame. A lost or extra copy strobe appears at the next frame start as stale or early pixels. A blink phase that flips when it should not shows the wrong image at the next blink tick. A mode that is applied too early changes the pixels inside the current frame. Faults in the shutdown path show up at the frame boundary: `allGround` rises one frame too early or too late, or `disIrq` and `disBusy` are wrong in the cycle after the all-ground frame ends. A buffer lost on disable or kept across a soft reset shows in the first cycle after the block is turned on again.

// File: rtl/segSeqPkg.sv
package segSeqPkg;

  localparam logic [2:0] CODE_NORMAL = 3'd0;
  localparam logic [2:0] CODE_BLINK  = 3'd1;
  localparam logic [2:0] CODE_LOAD   = 3'd6;
  localparam logic [2:0] CODE_SWAP   = 3'd7;

  typedef enum logic [1:0] {
    MODE_NORMAL,
    MODE_BLINK,
    MODE_LOAD,
    MODE_SWAP
  } dispMode_e;

  typedef enum logic [1:0] {
    SRC_DISP,
    SRC_USER,
    SRC_OFF
  } pixSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    loadDisp;  // copy user buffer into display buffer
    logic    wipe;      // clear both buffers
    pixSrc_e src;       // which image drives the segments
  } seqStrobe_t;

  // Unknown codes fall back to normal refresh
  function automatic dispMode_e decodeMode(input logic [2:0] code);
    case (code)
      CODE_BLINK: return MODE_BLINK;
      CODE_LOAD:  return MODE_LOAD;
      CODE_SWAP:  return MODE_SWAP;
      default:    return MODE_NORMAL;
    endcase
  endfunction

  function automatic logic copiesEachFrame(input dispMode_e m);
    return (m == MODE_NORMAL) || (m == MODE_BLINK);
  endfunction

  function automatic logic usesBlink(input dispMode_e m);
    return (m == MODE_BLINK) || (m == MODE_SWAP);
  endfunction

endpackage

// File: rtl/segSeqCtrl.sv
module segSeqCtrl
  import segSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       blinkTick,
  input  logic       cfgWr,
  input  logic [2:0] cfgMode,
  input  logic       cfgIrqEn,
  input  logic       enableReq,
  input  logic       disableReq,
  input  logic       softReset,
  input  logic       irqClr,
  output seqStrobe_t strb,
  output logic       allGround,
  output logic       disIrq,
  output logic       active,
  output logic       disBusy
);

  dispMode_e pendMode, actMode;
  logic      phase;
  logic      enabled;
  logic      disPend;
  logic      gndFrame;
  logic      irqFlag;
  logic      irqEn;
  logic      gndDone;

  assign gndDone = gndFrame && frameEnd;

  // Mode register and frame-boundary application
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMode <= MODE_NORMAL;
      actMode  <= MODE_NORMAL;
      irqEn    <= 1'b0;
    end else if (softReset) begin
      pendMode <= MODE_NORMAL;
      actMode  <= MODE_NORMAL;
      irqEn    <= 1'b0;
    end else begin
      if (cfgWr) begin
        pendMode <= decodeMode(cfgMode);
        irqEn    <= cfgIrqEn;
      end
      if (frameStart) actMode <= pendMode;
    end
  end

  // Blink phase: toggles on ticks, restarts on a mode change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 1'b0;
    end else if (softReset) begin
      phase <= 1'b0;
    end else if (frameStart && (pendMode != actMode)) begin
      phase <= 1'b0;
    end else if (blinkTick && usesBlink(actMode)) begin
      phase <= ~phase;
    end
  end

  // Enable / disable sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled  <= 1'b0;
      disPend  <= 1'b0;
      gndFrame <= 1'b0;
    end else if (softReset) begin
      enabled  <= 1'b0;
      disPend  <= 1'b0;
      gndFrame <= 1'b0;
    end else if (gndDone) begin
      enabled  <= 1'b0;
      disPend  <= 1'b0;
      gndFrame <= 1'b0;
    end else begin
      if (enableReq && !disPend) enabled <= 1'b1;
      if (disableReq && enabled) disPend <= 1'b1;
      if (frameStart && disPend && enabled) gndFrame <= 1'b1;
    end
  end

  // Interrupt flag: set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (softReset) begin
      irqFlag <= 1'b0;
    end else if (gndDone) begin
      irqFlag <= 1'b1;
    end else if (irqClr) begin
      irqFlag <= 1'b0;
    end
  end

  // Strobes to the datapath
  always_comb begin
    strb.wipe     = softReset;
    strb.loadDisp = frameStart && enabled && copiesEachFrame(pendMode);
    if (!enabled || gndFrame) begin
      strb.src = SRC_OFF;
    end else begin
      case (actMode)
        MODE_BLINK: strb.src = phase ? SRC_OFF : SRC_DISP;
        MODE_SWAP:  strb.src = phase ? SRC_USER : SRC_DISP;
        default:    strb.src = SRC_DISP;
      endcase
    end
  end

  assign allGround = !enabled || gndFrame;
  assign disIrq    = irqFlag && irqEn;
  assign active    = enabled;
  assign disBusy   = disPend;

  AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !softReset) |=> $stable(actMode)); // R3

  AST_GND_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    gndFrame |-> disPend); // R7

  AST_DONE_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (gndFrame && frameEnd && !softReset) |=> (!disBusy && !active && irqFlag)); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr && !softReset) |=> irqFlag); // R9

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (!active && !disBusy && !irqFlag && allGround)); // R11

endmodule

// File: rtl/segSeqData.sv
module segSeqData
  import segSeqPkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 8,
  localparam int NUM_PIX  = NUM_WORDS * WORD_W,
  localparam int ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic               bufWr,
  input  logic [ADDR_W-1:0]  bufAddr,
  input  logic [WORD_W-1:0]  bufData,
  output logic [NUM_PIX-1:0] pixOut
);

  logic [NUM_PIX-1:0] userBuf;
  logic [NUM_PIX-1:0] dispBuf;

  // User buffer, word-addressed writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      userBuf <= '0;
    end else if (strb.wipe) begin
      userBuf <= '0;
    end else if (bufWr) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (bufAddr == ADDR_W'(w)) userBuf[w*WORD_W +: WORD_W] <= bufData;
      end
    end
  end

  // Display buffer, loaded whole at frame start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispBuf <= '0;
    end else if (strb.wipe) begin
      dispBuf <= '0;
    end else if (strb.loadDisp) begin
      dispBuf <= userBuf;
    end
  end

  // Per-word output selection
  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWordMux
    always_comb begin
      case (strb.src)
        SRC_DISP: pixOut[g*WORD_W +: WORD_W] = dispBuf[g*WORD_W +: WORD_W];
        SRC_USER: pixOut[g*WORD_W +: WORD_W] = userBuf[g*WORD_W +: WORD_W];
        default:  pixOut[g*WORD_W +: WORD_W] = '0;
      endcase
    end
  end

  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadDisp && !strb.wipe) |=> $stable(dispBuf)); // R4

  AST_WIPE_BUFS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> (userBuf == '0 && dispBuf == '0)); // R11

endmodule

// File: rtl/segFrameSeq.sv
module segFrameSeq
  import segSeqPkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 8,
  localparam int NUM_PIX  = NUM_WORDS * WORD_W,
  localparam int ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               frameEnd,
  input  logic               blinkTick,
  input  logic               cfgWr,
  input  logic [2:0]         cfgMode,
  input  logic               cfgIrqEn,
  input  logic               enableReq,
  input  logic               disableReq,
  input  logic               softReset,
  input  logic               irqClr,
  input  logic               bufWr,
  input  logic [ADDR_W-1:0]  bufAddr,
  input  logic [WORD_W-1:0]  bufData,
  output logic [NUM_PIX-1:0] pixOut,
  output logic               allGround,
  output logic               disIrq,
  output logic               active,
  output logic               disBusy
);

  seqStrobe_t strb;

  segSeqCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .frameEnd  (frameEnd),
    .blinkTick (blinkTick),
    .cfgWr     (cfgWr),
    .cfgMode   (cfgMode),
    .cfgIrqEn  (cfgIrqEn),
    .enableReq (enableReq),
    .disableReq(disableReq),
    .softReset (softReset),
    .irqClr    (irqClr),
    .strb      (strb),
    .allGround (allGround),
    .disIrq    (disIrq),
    .active    (active),
    .disBusy   (disBusy)
  );

  segSeqData #(
    .NUM_WORDS(NUM_WORDS),
    .WORD_W   (WORD_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .bufWr  (bufWr),
    .bufAddr(bufAddr),
    .bufData(bufData),
    .pixOut (pixOut)
  );

  AST_GND_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    allGround |-> (pixOut == '0)); // R7

endmodule

// File: tb/tb_segFrameSeq.sv
module tb_segFrameSeq;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int WW = 8;

  localparam logic [1:0] OP_WR   = 2'd0;
  localparam logic [1:0] OP_FRM  = 2'd1;
  localparam logic [1:0] OP_TICK = 2'd2;
  localparam logic [1:0] OP_MODE = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  a;
    logic [7:0]  d;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{OP_WR,   8'd0, 8'hA5, 32'h00000000, 8'd2},  // R2 not yet copied
    '{OP_FRM,  8'd0, 8'h00, 32'h000000A5, 8'd2},  // R2 copy at frame start
    '{OP_WR,   8'd3, 8'h3C, 32'h000000A5, 8'd2},
    '{OP_FRM,  8'd0, 8'h00, 32'h3C0000A5, 8'd2},
    '{OP_MODE, 8'd6, 8'h00, 32'h3C0000A5, 8'd3},  // R3 pending only
    '{OP_WR,   8'd1, 8'hFF, 32'h3C0000A5, 8'd4},
    '{OP_FRM,  8'd0, 8'h00, 32'h3C0000A5, 8'd4},  // R4 load-only, no copy
    '{OP_WR,   8'd2, 8'h11, 32'h3C0000A5, 8'd4},
    '{OP_FRM,  8'd0, 8'h00, 32'h3C0000A5, 8'd4},
    '{OP_MODE, 8'd7, 8'h00, 32'h3C0000A5, 8'd3},
    '{OP_TICK, 8'd0, 8'h00, 32'h3C0000A5, 8'd3},  // R3 still load-only
    '{OP_FRM,  8'd0, 8'h00, 32'h3C0000A5, 8'd5},  // R5 swap starts on display
    '{OP_TICK, 8'd0, 8'h00, 32'h3C11FFA5, 8'd5},
    '{OP_TICK, 8'd0, 8'h00, 32'h3C0000A5, 8'd5},
    '{OP_TICK, 8'd0, 8'h00, 32'h3C11FFA5, 8'd5},
    '{OP_MODE, 8'd1, 8'h00, 32'h3C11FFA5, 8'd3},
    '{OP_FRM,  8'd0, 8'h00, 32'h3C11FFA5, 8'd6},  // R6 blink, copied, shown
    '{OP_TICK, 8'd0, 8'h00, 32'h00000000, 8'd6},
    '{OP_TICK, 8'd0, 8'h00, 32'h3C11FFA5, 8'd6},
    '{OP_MODE, 8'd4, 8'h00, 32'h3C11FFA5, 8'd12},
    '{OP_FRM,  8'd0, 8'h00, 32'h3C11FFA5, 8'd12}, // R12 code 4 as normal
    '{OP_TICK, 8'd0, 8'h00, 32'h3C11FFA5, 8'd12},
    '{OP_WR,   8'd0, 8'h00, 32'h3C11FFA5, 8'd12},
    '{OP_FRM,  8'd0, 8'h00, 32'h3C11FF00, 8'd12}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0, frameEnd = 1'b0, blinkTick = 1'b0;
  logic        cfgWr = 1'b0, cfgIrqEn = 1'b0;
  logic [2:0]  cfgMode = 3'd0;
  logic        enableReq = 1'b0, disableReq = 1'b0, softReset = 1'b0, irqClr = 1'b0;
  logic        bufWr = 1'b0;
  logic [1:0]  bufAddr = 2'd0;
  logic [7:0]  bufData = 8'd0;
  logic [31:0] pixOut;
  logic        allGround, disIrq, active, disBusy;

  int nChecks = 0;
  int nFails = 0;

  segFrameSeq #(.NUM_WORDS(NW), .WORD_W(WW)) dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .blinkTick(blinkTick), .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgIrqEn(cfgIrqEn),
    .enableReq(enableReq), .disableReq(disableReq), .softReset(softReset),
    .irqClr(irqClr), .bufWr(bufWr), .bufAddr(bufAddr), .bufData(bufData),
    .pixOut(pixOut), .allGround(allGround), .disIrq(disIrq), .active(active),
    .disBusy(disBusy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseStart();  frameStart = 1'b1; step(); frameStart = 1'b0; endtask
  task automatic pulseEnd();    frameEnd   = 1'b1; step(); frameEnd   = 1'b0; endtask
  task automatic pulseTick();   blinkTick  = 1'b1; step(); blinkTick  = 1'b0; endtask
  task automatic pulseEnable(); enableReq  = 1'b1; step(); enableReq  = 1'b0; endtask
  task automatic pulseDisable();disableReq = 1'b1; step(); disableReq = 1'b0; endtask

  task automatic doFrame();
    pulseStart();
    step();
    pulseEnd();
  endtask

  task automatic doCfg(input logic [2:0] m, input logic ie);
    cfgMode = m; cfgIrqEn = ie; cfgWr = 1'b1;
    step();
    cfgWr = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    bufAddr = a; bufData = d; bufWr = 1'b1;
    step();
    bufWr = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 allGround", 32'(allGround), 32'd1);
    chk("R1 pixOut", pixOut, 32'd0);
    chk("R1 active", 32'(active), 32'd0);
    chk("R1 disBusy", 32'(disBusy), 32'd0);
    chk("R1 disIrq", 32'(disIrq), 32'd0);
    pulseEnable();
    chk("R1 enable", {31'd0, active} | {30'd0, allGround, 1'b0}, 32'd1);
    doCfg(3'd0, 1'b1);

    // Vector table: R2 R3 R4 R5 R6 R12
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_WR:   doWrite(VECS[i].a[1:0], VECS[i].d);
        OP_FRM:  doFrame();
        OP_TICK: pulseTick();
        default: doCfg(VECS[i].a[2:0], 1'b1);
      endcase
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), pixOut, VECS[i].exp);
    end

    // R7 disable during a frame
    doCfg(3'd0, 1'b1);
    pulseStart();
    pulseDisable();
    chk("R7 disBusy set", 32'(disBusy), 32'd1);
    chk("R7 current frame still drawn", pixOut, 32'h3C11FF00);
    chk("R7 current frame not grounded", 32'(allGround), 32'd0);
    pulseEnd();
    pulseStart();
    chk("R7 ground frame", 32'(allGround), 32'd1);
    chk("R7 ground frame pixels", pixOut, 32'd0);
    chk("R8 no irq before end", 32'(disIrq), 32'd0);
    pulseEnd();
    // R8 completion
    chk("R8 disBusy cleared", 32'(disBusy), 32'd0);
    chk("R8 active cleared", 32'(active), 32'd0);
    chk("R8 irq raised", 32'(disIrq), 32'd1);
    // R9 hold until cleared
    repeat (3) step();
    chk("R9 irq held", 32'(disIrq), 32'd1);
    irqClr = 1'b1; step(); irqClr = 1'b0;
    chk("R9 irq cleared", 32'(disIrq), 32'd0);
    // R10 contents kept
    pulseEnable();
    chk("R10 display kept", pixOut, 32'h3C11FF00);
    chk("R10 not grounded", 32'(allGround), 32'd0);

    // R11 soft reset
    softReset = 1'b1; step(); softReset = 1'b0;
    chk("R11 active", 32'(active), 32'd0);
    chk("R11 allGround", 32'(allGround), 32'd1);
    chk("R11 pixOut", pixOut, 32'd0);
    pulseEnable();
    chk("R11 display cleared", pixOut, 32'd0);
    doFrame();
    chk("R11 user cleared", pixOut, 32'd0);

    // R8 masked interrupt, enable after completion
    pulseStart();
    pulseDisable();
    pulseEnd();
    pulseStart();
    pulseEnd();
    chk("R8 off after masked sequence", 32'(active), 32'd0);
    chk("R8 masked irq", 32'(disIrq), 32'd0);
    doCfg(3'd0, 1'b1);
    chk("R8 irq after enable bit", 32'(disIrq), 32'd1);

    finishRun();
  end

endmodule